// File: doc/BRIEF.md
# Frame-Credited Sequential Greedy Crossbar Scheduler

This block computes crossbar connections for an N-port switch that buffers cells at its inputs and honours per-pair bandwidth reservations. Time is cut into frames of F cell slots. Every input-output pair holds a credit count. The count is refilled from a writable reservation table when a frame begins, and it drops by one each time the pair is connected. Within a slot the inputs decide one after another, each claiming an output that no earlier input has taken in that slot. An input only claims an output for which it has a queued cell and credit left.

The decision chain is a pipeline with one stage per input. Stage i settles input i's choice for a slot while stage i-1 is already working on the following slot. The set of outputs still free travels with the slot from stage to stage. After the pipeline has filled, one complete slot schedule leaves the block on every clock. The schedule gives each input a valid bit and an output number. A cell-presence matrix comes in from the queues, and a single write port loads the reservation table.

Top module: `wsgs_sched`

## Requirements
- R1: While reset is held, `sched_valid` and every bit of `match_valid` are 0. After reset is released, the first slot schedule appears with `sched_valid` high on the (N+1)-th rising edge. From then on, one schedule appears on every clock.
- R2: `sched_frame_first` is 1 on the first scheduled slot after reset and on every F-th slot after it. It is 0 on all other slots.
- R3: Inputs decide in ascending order, 0 first. Each input takes the lowest-numbered output that is eligible for it.
- R4: Output j is eligible for input i when three things hold: no lower-numbered input took j in the same slot, occupancy bit `occ[i*N+j]` is 1, and the pair's credit is above zero.
- R5: The schedule is maximal. An input is left without a match only when no output is eligible for it. An input with no match does not change the set of free outputs.
- R6: At the first slot of each frame, every pair's credit is reloaded from its table entry before that slot's choice. Each connection lowers the pair's credit by exactly one. A credit at zero stays at zero until the next reload.
- R7: A table write is captured at the clock edge where `tab_we` is 1 and updates entry (`tab_row`, `tab_col`). The new value has no effect on the current frame and takes effect at the next frame reload. Reset does not clear the table, and the table accepts writes while reset is held.
- R8: For input i, the chosen output is the binary number in `match_port[i*IW +: IW]`, where IW = max(1, ceil(log2 N)). That field is meaningful only when `match_valid[i]` is 1.
- R9: Within one slot, no two valid matches name the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell slot enters the pipeline per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| occ | input | N*N | Cell presence; bit i*N+j set means input i holds a cell for output j |
| tab_we | input | 1 | Reservation table write strobe |
| tab_row | input | IW | Input index of the entry being written |
| tab_col | input | IW | Output index of the entry being written |
| tab_val | input | CW | Reserved slots per frame for that pair, CW = ceil(log2(F+1)) |
| sched_valid | output | 1 | A slot schedule is present on the match outputs |
| sched_frame_first | output | 1 | The present schedule is the first slot of a frame |
| match_valid | output | N | Per-input match flag |
| match_port | output | N*IW | Per-input chosen output number |

## Verification
The bench builds the block with N=4 and a short frame of F=6. With a frame that short, credits of 0 to 6 run out within a single frame, and every run crosses several reloads. More than sixty cell-presence and reservation patterns are swept. Directed cases cover full contention for one output, an empty matrix, the identity pattern and a full matrix. A table write placed in the gap just after a frame's first slot leaves the pipeline, and before the next frame's first slot enters, shows that the new value waits for the reload. A reference model in the bench replays every slot and checks every input's outcome.

// File: rtl/wsgs_pkg.sv
package wsgs_pkg;
  // index width that stays legal for a single-entry range
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // credit counter width able to hold a full frame's worth
  function automatic int cred_w(input int f);
    return $clog2(f + 1);
  endfunction
endpackage

// File: rtl/wsgs_restab.sv
module wsgs_restab
  import wsgs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 5,
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [IW-1:0]     wr_col,
  input  logic [CW-1:0]     wr_val,
  output logic [N*N*CW-1:0] rows_flat
);
  logic [CW-1:0] tab_q [N][N];
  logic          wr_hit;

  assign wr_hit = wr_en && (int'(wr_row) < N) && (int'(wr_col) < N);

  // table is deliberately not reset: it is loaded while reset is held
  always_ff @(posedge clk) begin
    if (wr_hit) tab_q[wr_row][wr_col] <= wr_val;
  end

  always_comb begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        rows_flat[(r*N + c)*CW +: CW] = tab_q[r][c];
  end
endmodule

// File: rtl/wsgs_stage.sv
module wsgs_stage
  import wsgs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 5,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_live,
  input  logic            in_fresh,
  input  logic [N-1:0]    in_free,
  input  logic [N-1:0]    occ_row,
  input  logic [N*CW-1:0] res_row,
  output logic            out_live,
  output logic            out_fresh,
  output logic [N-1:0]    out_free,
  output logic            pick_valid,
  output logic [IW-1:0]   pick_port
);
  logic [CW-1:0] cnt_q [N];
  logic [CW-1:0] eff   [N];
  logic [N-1:0]  elig;
  logic [N-1:0]  take_vec;
  logic          any_elig;
  logic [IW-1:0] sel;

  function automatic logic [IW-1:0] lowest_idx(input logic [N-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int j = N - 1; j >= 0; j--)
      if (m[j]) r = IW'(j);
    return r;
  endfunction

  function automatic logic [N-1:0] to_onehot(input logic en, input logic [IW-1:0] ix);
    logic [N-1:0] v;
    v = '0;
    for (int j = 0; j < N; j++)
      if (en && int'(ix) == j) v[j] = 1'b1;
    return v;
  endfunction

  // credit seen by this slot: reloaded value on a frame's first slot
  always_comb begin
    for (int j = 0; j < N; j++) begin
      eff[j]  = in_fresh ? res_row[j*CW +: CW] : cnt_q[j];
      elig[j] = in_free[j] & occ_row[j] & (eff[j] != '0);
    end
  end

  assign any_elig = |elig;
  assign sel      = lowest_idx(elig);
  assign take_vec = to_onehot(any_elig, sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) cnt_q[j] <= '0;
      out_live   <= 1'b0;
      out_fresh  <= 1'b0;
      out_free   <= '0;
      pick_valid <= 1'b0;
      pick_port  <= '0;
    end else begin
      if (in_live)
        for (int j = 0; j < N; j++) cnt_q[j] <= eff[j] - CW'(take_vec[j]);
      out_live   <= in_live;
      out_fresh  <= in_live & in_fresh;
      out_free   <= in_free & ~take_vec;
      pick_valid <= in_live & any_elig;
      pick_port  <= sel;
    end
  end

  a_r4_take_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    (in_live && any_elig) |-> ((take_vec & ~in_free) == '0))
    else $error("R4 output taken that an earlier input already holds");

  a_r4_take_has_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (in_live && any_elig) |-> ((take_vec & ~occ_row) == '0))
    else $error("R4 output taken without a queued cell");

  generate
    for (genvar g = 0; g < N; g++) begin : g_cred_chk
      a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_live && !in_fresh && cnt_q[g] == '0) |=> (cnt_q[g] == '0))
        else $error("R6 credit left zero without a reload");

      a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_live && take_vec[g]) |=> (cnt_q[g] == $past(eff[g]) - CW'(1)))
        else $error("R6 credit did not drop by one on a grant");
    end
  endgenerate
endmodule

// File: rtl/wsgs_skew.sv
module wsgs_skew #(
  parameter int W     = 3,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] sr_q [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int d = 0; d < DEPTH; d++) sr_q[d] <= '0;
        end else begin
          sr_q[0] <= din;
          for (int d = 1; d < DEPTH; d++) sr_q[d] <= sr_q[d-1];
        end
      end
      assign dout = sr_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/wsgs_sched.sv
module wsgs_sched
  import wsgs_pkg::*;
#(
  parameter int  N  = 4,
  parameter int  F  = 16,
  localparam int CW = cred_w(F),
  localparam int IW = idx_w(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*N-1:0]  occ,
  input  logic            tab_we,
  input  logic [IW-1:0]   tab_row,
  input  logic [IW-1:0]   tab_col,
  input  logic [CW-1:0]   tab_val,
  output logic            sched_valid,
  output logic            sched_frame_first,
  output logic [N-1:0]    match_valid,
  output logic [N*IW-1:0] match_port
);
  localparam int FW   = idx_w(F);
  localparam int FILL = N + 1;
  localparam int LW   = $clog2(FILL + 1);

  logic              live_q;
  logic [FW-1:0]     slot_q;
  logic              entry_fresh;
  logic [N*N*CW-1:0] tab_rows;

  logic [N:0]        lv;
  logic [N:0]        fr;
  logic [N-1:0]      fm [N+1];

  // slot source: a new slot enters stage 0 on every cycle after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= '0;
    end else begin
      live_q <= 1'b1;
      if (live_q) slot_q <= (slot_q == FW'(F - 1)) ? '0 : slot_q + FW'(1);
    end
  end

  assign entry_fresh = (slot_q == '0);
  assign lv[0] = live_q;
  assign fr[0] = entry_fresh;
  assign fm[0] = '1;

  wsgs_restab #(.N(N), .CW(CW), .IW(IW)) u_tab (
    .clk      (clk),
    .wr_en    (tab_we),
    .wr_row   (tab_row),
    .wr_col   (tab_col),
    .wr_val   (tab_val),
    .rows_flat(tab_rows)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_in
      logic          pv;
      logic [IW-1:0] pp;
      logic [IW:0]   aligned;

      wsgs_stage #(.N(N), .CW(CW), .IW(IW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_live   (lv[i]),
        .in_fresh  (fr[i]),
        .in_free   (fm[i]),
        .occ_row   (occ[i*N +: N]),
        .res_row   (tab_rows[i*N*CW +: N*CW]),
        .out_live  (lv[i+1]),
        .out_fresh (fr[i+1]),
        .out_free  (fm[i+1]),
        .pick_valid(pv),
        .pick_port (pp)
      );

      // early stages wait so that all inputs of one slot leave together
      wsgs_skew #(.W(IW + 1), .DEPTH(N - 1 - i)) u_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pv, pp}),
        .dout (aligned)
      );

      assign match_valid[i]           = aligned[IW];
      assign match_port[i*IW +: IW]   = aligned[IW-1:0];
    end
  endgenerate

  assign sched_valid       = lv[N];
  assign sched_frame_first = fr[N];

  // checker-side fill counter for the latency property
  logic [LW-1:0] fill_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                  fill_q <= '0;
    else if (fill_q != LW'(FILL)) fill_q <= fill_q + LW'(1);
  end

  a_r1_fill_latency: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid == (fill_q == LW'(FILL)))
    else $error("R1 schedule timing does not match pipeline depth");

  a_r1_quiet_match: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_valid |-> (match_valid == '0))
    else $error("R1 match flagged outside a schedule");

  always @(posedge clk) begin
    if (rst_n && sched_valid) begin
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++)
          a_r9_distinct: assert (!(match_valid[a] && match_valid[b] &&
                                   match_port[a*IW +: IW] == match_port[b*IW +: IW]))
            else $error("R9 two inputs share output in one slot");
    end
  end
endmodule

// File: tb/sim_wsgs_sched.sv
`timescale 1ns/1ps
module sim_wsgs_sched;
  localparam int N  = 4;
  localparam int F  = 6;
  localparam int CW = $clog2(F + 1);
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*N-1:0]  occ = '0;
  logic            tab_we = 1'b0;
  logic [IW-1:0]   tab_row = '0;
  logic [IW-1:0]   tab_col = '0;
  logic [CW-1:0]   tab_val = '0;
  logic            sched_valid;
  logic            sched_frame_first;
  logic [N-1:0]    match_valid;
  logic [N*IW-1:0] match_port;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int tab_m  [N][N];
  int cred_m [N][N];
  int out_idx;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  wsgs_sched #(.N(N), .F(F)) u0 (
    .clk(clk), .rst_n(rst_n), .occ(occ),
    .tab_we(tab_we), .tab_row(tab_row), .tab_col(tab_col), .tab_val(tab_val),
    .sched_valid(sched_valid), .sched_frame_first(sched_frame_first),
    .match_valid(match_valid), .match_port(match_port)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic put_tab(input int r, input int c, input int v);
    tab_row = IW'(r); tab_col = IW'(c); tab_val = CW'(v); tab_we = 1'b1;
    tab_m[r][c] = v;
    @(negedge clk);
    tab_we = 1'b0;
  endtask

  // model of one slot; checks every input of the schedule on the ports
  task automatic check_slot(input string tag);
    logic [N-1:0] free;
    int got_p;
    bit dup;
    chk(sched_frame_first === ((out_idx % F) == 0), "R2 frame flag",
        int'(sched_frame_first), int'((out_idx % F) == 0));
    free = '1;
    for (int i = 0; i < N; i++) begin
      int pick;
      pick = -1;
      if (out_idx % F == 0)
        for (int j = 0; j < N; j++) cred_m[i][j] = tab_m[i][j];
      for (int j = N - 1; j >= 0; j--)
        if (free[j] && occ[i*N + j] && cred_m[i][j] > 0) pick = j;
      got_p = int'(match_port[i*IW +: IW]);
      if (pick < 0) begin
        chk(match_valid[i] === 1'b0, {tag, " R5 idle input"}, int'(match_valid[i]), 0);
      end else begin
        chk(match_valid[i] === 1'b1 && got_p == pick, {tag, " R3 R4 R8 pick"},
            match_valid[i] ? got_p : -1, pick);
        free[pick] = 1'b0;
        cred_m[i][pick]--;
      end
    end
    dup = 0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (match_valid[a] && match_valid[b] &&
            match_port[a*IW +: IW] == match_port[b*IW +: IW]) dup = 1;
    chk(!dup, "R9 distinct outputs", int'(dup), 0);
    out_idx++;
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    if (sched_valid) check_slot(tag);
  endtask

  // hold reset, load table and occupancy, release
  task automatic setup(input logic [N*N-1:0] o, input int mode);
    @(negedge clk);
    rst_n = 1'b0;
    occ = o;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int v;
        lfsr = step(lfsr);
        case (mode)
          0: v = int'(lfsr[2:0]) % (F + 1);
          1: v = F;
          default: v = 1;
        endcase
        put_tab(r, c, v);
      end
    @(negedge clk);
    chk(sched_valid === 1'b0 && match_valid === '0, "R1 reset quiet",
        int'(sched_valid), 0);
    rst_n = 1'b1;
    out_idx = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 latency after release
    setup('1, 1);
    for (int e = 1; e <= N + 1; e++) begin
      @(negedge clk);
      chk(sched_valid === (e == N + 1), "R1 fill latency", int'(sched_valid), int'(e == N + 1));
    end
    check_slot("R1 first slot");
    repeat (3 * F) tick("R6 full credits");

    // directed: all inputs want only output 0, one credit each
    setup({N{4'b0001}}, 2);
    repeat (2 * F + N) tick("R3 contention");

    // directed: empty matrix
    setup('0, 1);
    repeat (F + N) tick("R5 empty");

    // directed: identity
    setup(16'b1000_0100_0010_0001, 2);
    repeat (2 * F + N) tick("R4 identity");

    // R7: write just after a frame's first slot leaves the pipeline
    setup('1, 1);
    while (out_idx != F + 1) tick("R7 before write");
    tab_row = 2'd0; tab_col = 2'd0; tab_val = CW'(0); tab_we = 1'b1;
    tab_m[0][0] = 0;
    tick("R7 old table still in use");
    tab_we = 1'b0;
    repeat (2 * F) tick("R7 new table");

    // sweep of patterns with mixed credits
    for (int p = 0; p < 64; p++) begin
      lfsr = step(lfsr);
      setup(lfsr[15:0] | lfsr[31:16], 0);
      repeat (2 * F + N + 2) tick("R6 sweep");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule